// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags

This block sits behind a UART deserialiser. Each received character enters a FIFO together with three tag bits: parity error, framing error and break. The status outputs always describe the character at the head of the FIFO. A separate aggregate flag shows whether any character still held in the FIFO carries a tag. That flag is kept by a counter of tagged entries. It stays set until every tagged entry has been popped, so a read of the status register does not clear it.

The block also watches the raw receive line, using the bit-time tick. If the line stays low for longer than one complete frame, the block stores exactly one zero character tagged as a break, however long the line then stays low.

The aggregate flag has two uses. It withholds the receive DMA request while any tagged character is present, and when DMA is enabled it raises an error interrupt instead. In single-character mode the store holds one entry and the aggregate flag reads 0.

Top module: `rxq_top`

## Requirements
- R1: `dataReady` is 1 exactly when at least one character is stored. `headData` shows the characters in the order they arrived, and a pop when empty is ignored.
- R2: The parity and framing flags given with each character are stored with it and appear on `headPe` and `headFe` while it is at the head.
- R3: A character that arrives while the store is full is dropped and `overrun` goes to 1. The store is full at DEPTH entries in FIFO mode and at 1 entry in single-character mode. A pulse on `statusRead` clears `overrun` when there is no new drop in the same cycle.
- R4: In FIFO mode, `fifoErr` is 1 while any stored character has a parity, framing or break tag. A status read does not clear it. It returns to 0 once the last tagged character has been popped.
- R5: With `fifoMode` = 0, `fifoErr` reads 0 even when a tagged character is stored, and the store holds one character.
- R6: `dmaReq` is 1 when all of the following hold: `dmaEn` = 1, `fifoMode` = 1, the fill level is at least `trigLevel` and non-zero, and `fifoErr` = 0. It comes back without any other action once the tagged characters are popped.
- R7: `errIrq` is 1 exactly when `dmaEn` = 1 and `fifoErr` = 1. With `dmaEn` = 0 it stays 0.
- R8: The frame length F in bit times is 7 + `dataSel` + `parityEn` + `stopTwo`, where `dataSel` 0..3 selects 5..8 data bits. While `rxLine` is low, the block counts `bitTick` pulses. On tick number F+1 it stores one character 0x00 with the break tag set. Further low time stores nothing more.
- R9: After a break, detection starts again only once a `bitTick` has arrived while `rxLine` is high. Low time before that tick stores nothing.
- R10: `headBreak` shows the break tag of the head character, not of the newest one. A `statusRead` hides it for that character. The next pop makes `headBreak` follow the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoMode | input | 1 | 1 = FIFO mode, 0 = single-character mode |
| dmaEn | input | 1 | Receive DMA enable |
| trigLevel | input | AW+1 | Fill level at which the DMA request is raised |
| dataSel | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Frame carries a parity bit |
| stopTwo | input | 1 | Frame has two stop bits |
| charValid | input | 1 | Deserialised character strobe |
| charData | input | 8 | Deserialised character |
| charPe | input | 1 | Parity error for that character |
| charFe | input | 1 | Framing error for that character |
| rxLine | input | 1 | Raw serial input |
| bitTick | input | 1 | One pulse per bit time |
| popReq | input | 1 | Remove the head character |
| statusRead | input | 1 | Status register read strobe |
| dataReady | output | 1 | Store non-empty |
| headData | output | 8 | Head character |
| headPe | output | 1 | Head parity error |
| headFe | output | 1 | Head framing error |
| headBreak | output | 1 | Head break tag, unless hidden by a status read |
| fifoErr | output | 1 | Some stored character is tagged |
| overrun | output | 1 | A character was dropped |
| dmaReq | output | 1 | Receive DMA request |
| errIrq | output | 1 | Error interrupt |

## Verification
The assertions check on every cycle that:
- the tagged-entry count never exceeds the fill level and is zero when the store is empty;
- the control never pushes into a full store or pops an empty one;
- a break never stores two characters in consecutive cycles.

Only the directed scenarios can show the behaviours that depend on history:
- arrival order;
- the aggregate flag surviving a status read and clearing on the last tagged pop;
- the DMA request returning after the drain;
- the exact tick on which a break is caught;
- the need for a high tick before a second break.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       brk;
  } rxEntry_t;

  typedef struct packed {
    logic     push;
    logic     pop;
    rxEntry_t wrEntry;
  } rxStrobe_t;
endpackage

// File: rtl/rxq_data.sv
module rxq_data import rxq_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic      clk,
  input  logic      rstN,
  input  rxStrobe_t strobe,
  output rxEntry_t  headEntry,
  output logic [AW:0] count
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  rxEntry_t mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= strobe.wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];

  assert_push_has_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count < FULL_LVL));
  assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl import rxq_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoMode,
  input  logic        dmaEn,
  input  logic [AW:0] trigLevel,
  input  logic [1:0]  dataSel,
  input  logic        parityEn,
  input  logic        stopTwo,
  input  logic        charValid,
  input  logic [7:0]  charData,
  input  logic        charPe,
  input  logic        charFe,
  input  logic        rxLine,
  input  logic        bitTick,
  input  logic        popReq,
  input  logic        statusRead,
  input  logic [AW:0] count,
  input  rxEntry_t    headEntry,
  output rxStrobe_t   strobe,
  output logic        dataReady,
  output logic        headBreak,
  output logic        fifoErr,
  output logic        overrun,
  output logic        dmaReq,
  output logic        errIrq
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [3:0] frameLen, lowCnt;
  logic armed, brkPush, brkAck, full, pushReq, pushTag, headTag;
  logic [AW:0] errCnt;
  rxEntry_t pushEntry;

  assign frameLen = 4'd7 + {2'b00, dataSel} + {3'b000, parityEn} + {3'b000, stopTwo};
  assign brkPush  = !rxLine && bitTick && armed && (lowCnt == frameLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      armed  <= 1'b1;
    end else if (rxLine) begin
      lowCnt <= '0;
      if (bitTick) armed <= 1'b1;
    end else if (bitTick && armed) begin
      if (brkPush) begin
        lowCnt <= '0;
        armed  <= 1'b0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign full      = fifoMode ? (count == FULL_LVL) : (count != '0);
  assign dataReady = (count != '0);
  assign pushReq   = brkPush || charValid;
  assign pushEntry = brkPush ? '{data: 8'h00, pe: 1'b0, fe: 1'b0, brk: 1'b1}
                             : '{data: charData, pe: charPe, fe: charFe, brk: 1'b0};
  assign pushTag   = pushEntry.pe || pushEntry.fe || pushEntry.brk;
  assign headTag   = headEntry.pe || headEntry.fe || headEntry.brk;

  always_comb begin
    strobe.push    = pushReq && !full;
    strobe.pop     = popReq && dataReady;
    strobe.wrEntry = pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt  <= '0;
      overrun <= 1'b0;
      brkAck  <= 1'b0;
    end else begin
      case ({strobe.push && pushTag, strobe.pop && headTag})
        2'b10:   errCnt <= errCnt + 1'b1;
        2'b01:   errCnt <= errCnt - 1'b1;
        default: errCnt <= errCnt;
      endcase
      if (pushReq && full)   overrun <= 1'b1;
      else if (statusRead)   overrun <= 1'b0;
      if (strobe.pop)                    brkAck <= 1'b0;
      else if (statusRead && dataReady)  brkAck <= 1'b1;
    end
  end

  assign headBreak = dataReady && headEntry.brk && !brkAck;
  assign fifoErr   = fifoMode && (errCnt != '0);
  assign dmaReq    = dmaEn && fifoMode && dataReady && (count >= trigLevel) && !fifoErr;
  assign errIrq    = dmaEn && fifoErr;

  assert_errcnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= count);
  assert_empty_noerr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (errCnt == '0));
  assert_single_break_R8: assert property (@(posedge clk) disable iff (!rstN)
    brkPush |=> !brkPush);
endmodule

// File: rtl/rxq_top.sv
module rxq_top import rxq_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoMode,
  input  logic        dmaEn,
  input  logic [AW:0] trigLevel,
  input  logic [1:0]  dataSel,
  input  logic        parityEn,
  input  logic        stopTwo,
  input  logic        charValid,
  input  logic [7:0]  charData,
  input  logic        charPe,
  input  logic        charFe,
  input  logic        rxLine,
  input  logic        bitTick,
  input  logic        popReq,
  input  logic        statusRead,
  output logic        dataReady,
  output logic [7:0]  headData,
  output logic        headPe,
  output logic        headFe,
  output logic        headBreak,
  output logic        fifoErr,
  output logic        overrun,
  output logic        dmaReq,
  output logic        errIrq
);
  rxStrobe_t   strobe;
  rxEntry_t    headEntry;
  logic [AW:0] count;

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .dmaEn(dmaEn),
    .trigLevel(trigLevel), .dataSel(dataSel), .parityEn(parityEn),
    .stopTwo(stopTwo), .charValid(charValid), .charData(charData),
    .charPe(charPe), .charFe(charFe), .rxLine(rxLine), .bitTick(bitTick),
    .popReq(popReq), .statusRead(statusRead), .count(count),
    .headEntry(headEntry), .strobe(strobe), .dataReady(dataReady),
    .headBreak(headBreak), .fifoErr(fifoErr), .overrun(overrun),
    .dmaReq(dmaReq), .errIrq(errIrq)
  );

  rxq_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headEntry(headEntry), .count(count)
  );

  assign headData = headEntry.data;
  assign headPe   = headEntry.pe;
  assign headFe   = headEntry.fe;
endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoMode = 1'b1, dmaEn = 1'b0;
  logic [AW:0] trigLevel = 1;
  logic [1:0] dataSel = 2'd3;
  logic parityEn = 1'b0, stopTwo = 1'b0;
  logic charValid = 1'b0, charPe = 1'b0, charFe = 1'b0;
  logic [7:0] charData = 8'h00;
  logic rxLine = 1'b1, bitTick = 1'b0, popReq = 1'b0, statusRead = 1'b0;
  logic dataReady, headPe, headFe, headBreak, fifoErr, overrun, dmaReq, errIrq;
  logic [7:0] headData;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .dmaEn(dmaEn),
    .trigLevel(trigLevel), .dataSel(dataSel), .parityEn(parityEn),
    .stopTwo(stopTwo), .charValid(charValid), .charData(charData),
    .charPe(charPe), .charFe(charFe), .rxLine(rxLine), .bitTick(bitTick),
    .popReq(popReq), .statusRead(statusRead), .dataReady(dataReady),
    .headData(headData), .headPe(headPe), .headFe(headFe),
    .headBreak(headBreak), .fifoErr(fifoErr), .overrun(overrun),
    .dmaReq(dmaReq), .errIrq(errIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushChar(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk); charValid = 1'b1; charData = d; charPe = pe; charFe = fe;
    @(negedge clk); charValid = 1'b0; charPe = 1'b0; charFe = 1'b0;
  endtask

  task automatic popOne();
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
  endtask

  task automatic statusRd();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitTick = 1'b1;
      @(negedge clk); bitTick = 1'b0;
    end
  endtask

  task automatic testReset();
    chk("R1 reset dataReady", dataReady, 0);
    chk("R4 reset fifoErr", fifoErr, 0);
    chk("R3 reset overrun", overrun, 0);
    chk("R6 reset dmaReq", dmaReq, 0);
    chk("R7 reset errIrq", errIrq, 0);
  endtask

  task automatic testOrderFlags();
    pushChar(8'h11, 0, 0);
    pushChar(8'h22, 1, 0);
    pushChar(8'h33, 0, 1);
    chk("R1 head first", headData, 8'h11);
    chk("R2 head clean pe", headPe, 0);
    chk("R4 fifoErr set", fifoErr, 1);
    statusRd();
    chk("R4 fifoErr survives status read", fifoErr, 1);
    popOne();
    chk("R1 head second", headData, 8'h22);
    chk("R2 head pe", headPe, 1);
    popOne();
    chk("R2 head fe", headFe, 1);
    chk("R4 fifoErr until last tagged pop", fifoErr, 1);
    popOne();
    chk("R1 empty", dataReady, 0);
    chk("R4 fifoErr cleared", fifoErr, 0);
    popOne();
    chk("R1 pop when empty ignored", dataReady, 0);
  endtask

  task automatic testDma();
    dmaEn = 1'b1; trigLevel = 4;
    pushChar(8'hA0, 0, 0);
    pushChar(8'hA1, 0, 0);
    pushChar(8'hA2, 0, 0);
    chk("R6 below trigger", dmaReq, 0);
    pushChar(8'hA3, 0, 0);
    chk("R6 at trigger", dmaReq, 1);
    while (dataReady) popOne();
    pushChar(8'hB0, 1, 0);
    for (int i = 0; i < 4; i++) pushChar(8'hB1 + 8'(i), 0, 0);
    chk("R6 withheld by fifoErr", dmaReq, 0);
    chk("R7 irq with dma", errIrq, 1);
    dmaEn = 1'b0; #1;
    chk("R7 no irq without dma", errIrq, 0);
    dmaEn = 1'b1;
    popOne();
    chk("R6 resumes after drain", dmaReq, 1);
    chk("R7 irq cleared", errIrq, 0);
    while (dataReady) popOne();
    dmaEn = 1'b0; trigLevel = 1;
  endtask

  task automatic testOverflow();
    for (int i = 0; i < DEPTH; i++) pushChar(8'h40 + 8'(i), 0, 0);
    chk("R3 no overrun when exactly full", overrun, 0);
    pushChar(8'hEE, 0, 0);
    chk("R3 overrun set", overrun, 1);
    statusRd();
    chk("R3 overrun cleared by status read", overrun, 0);
    for (int i = 0; i < DEPTH - 1; i++) popOne();
    chk("R3 extra character dropped", headData, 8'h40 + 8'(DEPTH - 1));
    popOne();
    chk("R3 drained", dataReady, 0);
  endtask

  task automatic testSingle();
    fifoMode = 1'b0;
    pushChar(8'h5A, 1, 0);
    chk("R5 fifoErr zero in single mode", fifoErr, 0);
    chk("R5 head pe still visible", headPe, 1);
    pushChar(8'h5B, 0, 0);
    chk("R5 second character overruns", overrun, 1);
    chk("R5 first character kept", headData, 8'h5A);
    statusRd();
    popOne();
    chk("R5 empty after pop", dataReady, 0);
    fifoMode = 1'b1;
  endtask

  task automatic testBreak();
    pushChar(8'h55, 0, 0);
    @(negedge clk); rxLine = 1'b0;
    ticks(10);
    chk("R8 no break at frame length", fifoErr, 0);
    ticks(1);
    chk("R8 break detected", fifoErr, 1);
    chk("R10 head is older char", headData, 8'h55);
    chk("R10 headBreak follows head", headBreak, 0);
    ticks(30);
    popOne();
    chk("R8 break char zero", headData, 8'h00);
    chk("R10 headBreak on head", headBreak, 1);
    statusRd();
    chk("R10 status read clears headBreak", headBreak, 0);
    chk("R10 char still stored", dataReady, 1);
    popOne();
    chk("R8 single break character", dataReady, 0);
    @(negedge clk); rxLine = 1'b1;
    @(negedge clk); rxLine = 1'b0;
    ticks(15);
    chk("R9 not rearmed without high tick", dataReady, 0);
    @(negedge clk); rxLine = 1'b1;
    ticks(1);
    @(negedge clk); rxLine = 1'b0;
    ticks(11);
    chk("R9 rearmed after high tick", headBreak, 1);
    @(negedge clk); rxLine = 1'b1;
    popOne();
    dataSel = 2'd0; parityEn = 1'b1; stopTwo = 1'b1;
    ticks(1);
    @(negedge clk); rxLine = 1'b0;
    ticks(9);
    chk("R8 short frame not yet", dataReady, 0);
    ticks(1);
    chk("R8 short frame break", headBreak, 1);
    @(negedge clk); rxLine = 1'b1;
    popOne();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrderFlags();
    testDma();
    testOverflow();
    testSingle();
    testBreak();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule